// File: doc/BRIEF.md
# Subvector Transpose Index Generator

This block produces a stream of paired element offsets, one for the source and one for the destination, for a vector operation whose elements are grouped into subvectors of SUBVL sub-elements (1 to 4). Each offset names element `i`, sub-element `j` at position `i*SUBVL + j`. Two walkers produce the offsets, one per side, and they step together. Each walker visits `(i, j)` in one of two nestings. In normal order the element loop is outer and the sub-element loop is inner. In swapped order the sub-element loop is outer and the element loop is inner. The `pack` flag selects swapped order for the source walker, and the `unpack` flag selects it for the destination walker. When exactly one flag is set, the pairs of offsets transpose the subvector data. Setting both flags is legal and gives a fixed, repeatable order.

A `start` pulse latches `vl`, `subvl`, `pack` and `unpack` and clears both walkers. From the next cycle, `valid` is high and the current pair is on `src_idx` and `dst_idx`. A high `step` in a valid cycle consumes that pair. After VL*SUBVL pairs have been consumed, `done` is high for one cycle.

Top module: `subvec_xpose_gen`

## Requirements
- R1: After reset, `valid` and `done` are both 0.
- R2: In the cycle after a `start` with `vl`>=1 and `subvl`>=1, `valid` is 1 and both `src_idx` and `dst_idx` are 0.
- R3: A walker in normal order (its flag clear) gives offset n for the n-th pair, counting from 0.
- R4: A walker in swapped order (its flag set) gives offset (n mod VL)*SUBVL + (n div VL) for the n-th pair. With VL=2 and SUBVL=3 this is 0,3,1,4,2,5.
- R5: The order of the source walker depends only on `pack`, and the order of the destination walker depends only on `unpack`. All four combinations of the two flags are legal.
- R6: A pair advances only on a clock edge where `valid` and `step` are both 1. In a valid cycle with `step`=0, both offsets hold.
- R7: Exactly VL*SUBVL pairs are presented. After the edge that consumes the last pair, `valid` is 0 and `done` is 1 for exactly one cycle.
- R8: With `subvl`=1, both offsets run 0..VL-1 whatever `pack` and `unpack` are.
- R9: A `start` with `vl`=0 or `subvl`=0 presents no pair, and `done` is 1 in the next cycle only.
- R10: A `start` during a walk abandons that walk and restarts from offset 0 with the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latch the configuration and begin a walk |
| vl | input | VLW | Number of elements, 0..VL_MAX |
| subvl | input | SUBW | Sub-elements per element, 0..SUBVL_MAX |
| pack | input | 1 | Swapped order for the source walker |
| unpack | input | 1 | Swapped order for the destination walker |
| step | input | 1 | Consume the current pair |
| src_idx | output | OW | Source element offset |
| dst_idx | output | OW | Destination element offset |
| valid | output | 1 | A pair is present on src_idx and dst_idx |
| done | output | 1 | One-cycle pulse after the final pair or after an empty start |

## Verification
The bench covers every VL from 0 to 8, every SUBVL from 1 to 4 and all four flag combinations. It stalls at irregular points, so a walker that wrapped its inner counter at the wrong bound, swapped the wrong side, or advanced on a stalled cycle would give a wrong offset mid-stream. The final pair and the `done` pulse are checked exactly. An off-by-one in the last-pair test would show up as one pair too many or too few, or as a `done` pulse that lasts two cycles. Empty starts and a restart in mid-walk are also run, because a walker that was not cleared on `start` would resume from stale counters.

// File: rtl/subvec_xpose_pkg.sv
package subvec_xpose_pkg;
   typedef enum logic {
      ORD_NORMAL = 1'b0,
      ORD_SWAP   = 1'b1
   } walk_order_e;
endpackage

// File: rtl/subvec_walker.sv
module subvec_walker
   import subvec_xpose_pkg::*;
#(
   parameter int VLW  = 4,
   parameter int SUBW = 3,
   parameter int OW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            adv,
   input  walk_order_e     order,
   input  logic [VLW-1:0]  vl_q,
   input  logic [SUBW-1:0] sub_q,
   output logic [OW-1:0]   off,
   output logic            last
);
   localparam int PW = VLW + SUBW;

   logic [VLW-1:0]  i_q;
   logic [SUBW-1:0] j_q;
   logic            i_end, j_end;
   logic [PW-1:0]   prod;

   assign i_end = (i_q == vl_q - VLW'(1));
   assign j_end = (j_q == sub_q - SUBW'(1));
   assign last  = i_end && j_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_q <= '0;
         j_q <= '0;
      end else if (clear) begin
         i_q <= '0;
         j_q <= '0;
      end else if (adv) begin
         if (order == ORD_NORMAL) begin
            if (j_end) begin
               j_q <= '0;
               i_q <= i_q + VLW'(1);
            end else begin
               j_q <= j_q + SUBW'(1);
            end
         end else begin
            if (i_end) begin
               i_q <= '0;
               j_q <= j_q + SUBW'(1);
            end else begin
               i_q <= i_q + VLW'(1);
            end
         end
      end
   end

   always_comb begin
      prod = PW'(i_q) * PW'(sub_q) + PW'(j_q);
      off  = OW'(prod);
   end

   // R6: an advance never leaves the sub-element counter past its bound
   a_r6_j_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clear) |=> (j_q < sub_q));
endmodule

// File: rtl/subvec_seq_ctrl.sv
module subvec_seq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic empty,
   input  logic step,
   input  logic last,
   output logic adv,
   output logic valid,
   output logic done
);
   logic fire;

   assign fire = valid && step;
   assign adv  = fire && !last && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         done  <= 1'b0;
      end else if (start) begin
         valid <= !empty;
         done  <= empty;
      end else if (fire && last) begin
         valid <= 1'b0;
         done  <= 1'b1;
      end else begin
         done  <= 1'b0;
      end
   end

   // R7: the done pulse lasts one cycle unless a new start intervened
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done);
   // R7: done and valid are never high together
   a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !valid);
endmodule

// File: rtl/subvec_xpose_gen.sv
module subvec_xpose_gen
   import subvec_xpose_pkg::*;
#(
   parameter int VL_MAX    = 8,
   parameter int SUBVL_MAX = 4,
   parameter int VLW       = $clog2(VL_MAX + 1),
   parameter int SUBW      = $clog2(SUBVL_MAX + 1),
   parameter int OW        = (VL_MAX * SUBVL_MAX > 1) ? $clog2(VL_MAX * SUBVL_MAX) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [VLW-1:0]  vl,
   input  logic [SUBW-1:0] subvl,
   input  logic            pack,
   input  logic            unpack,
   input  logic            step,
   output logic [OW-1:0]   src_idx,
   output logic [OW-1:0]   dst_idx,
   output logic            valid,
   output logic            done
);
   localparam int NSIDE = 2;
   localparam int TW    = VLW + SUBW;

   initial begin : a_cfg_params
      assert (VL_MAX >= 1) else $error("VL_MAX must be at least 1");
      assert (SUBVL_MAX >= 1 && SUBVL_MAX <= 4) else $error("SUBVL_MAX must be 1..4");
   end

   logic [VLW-1:0]  vl_q;
   logic [SUBW-1:0] sub_q;
   logic            pack_q, unpack_q;
   logic            adv;
   logic [OW-1:0]   offs [NSIDE];
   logic            lasts [NSIDE];
   logic            empty;
   logic [TW-1:0]   total;

   assign empty = (vl == '0) || (subvl == '0);
   assign total = TW'(vl_q) * TW'(sub_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vl_q     <= '0;
         sub_q    <= '0;
         pack_q   <= 1'b0;
         unpack_q <= 1'b0;
      end else if (start) begin
         vl_q     <= vl;
         sub_q    <= subvl;
         pack_q   <= pack;
         unpack_q <= unpack;
      end
   end

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         walk_order_e ord;
         if (s == 0) begin : g_src
            assign ord = pack_q ? ORD_SWAP : ORD_NORMAL;
         end else begin : g_dst
            assign ord = unpack_q ? ORD_SWAP : ORD_NORMAL;
         end
         subvec_walker #(.VLW(VLW), .SUBW(SUBW), .OW(OW)) u_walk (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (start),
            .adv   (adv),
            .order (ord),
            .vl_q  (vl_q),
            .sub_q (sub_q),
            .off   (offs[s]),
            .last  (lasts[s])
         );
      end
   endgenerate

   subvec_seq_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .empty (empty),
      .step  (step),
      .last  (lasts[0]),
      .adv   (adv),
      .valid (valid),
      .done  (done)
   );

   assign src_idx = offs[0];
   assign dst_idx = offs[1];

   // R7: both walkers reach their final pair together
   a_r7_last_match: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (lasts[0] == lasts[1]));
   // R3: offsets stay inside the VL*SUBVL element range
   a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (TW'(src_idx) < total && TW'(dst_idx) < total));
   // R6: a stalled valid cycle keeps both offsets
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !step && !start) |=> ($stable(src_idx) && $stable(dst_idx) && valid));
   // R2: a non-empty start begins at offset zero
   a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !empty) |=> (valid && src_idx == '0 && dst_idx == '0));
endmodule

// File: tb/subvec_xpose_gen_bench.sv
module subvec_xpose_gen_bench;
   localparam int VLW  = 4;
   localparam int SUBW = 3;
   localparam int OW   = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [VLW-1:0]  vl = '0;
   logic [SUBW-1:0] subvl = '0;
   logic            pack = 1'b0;
   logic            unpack = 1'b0;
   logic            step = 1'b0;
   logic [OW-1:0]   src_idx, dst_idx;
   logic            valid, done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   subvec_xpose_gen u_subvec_xpose_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .subvl(subvl),
      .pack(pack), .unpack(unpack), .step(step),
      .src_idx(src_idx), .dst_idx(dst_idx), .valid(valid), .done(done)
   );

   function automatic int expect_off(int n, int v, int s, bit sw);
      if (sw) return (n % v) * s + (n / v);
      return n;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
         finish_run();
      end
   end

   task automatic do_start(int v, int s, bit p, bit u);
      start = 1'b1; vl = VLW'(v); subvl = SUBW'(s); pack = p; unpack = u; step = 1'b0;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic walk(int v, int s, bit p, bit u, int stall_seed);
      int total = v * s;
      int n = 0;
      int k = 0;
      bit held = 1'b0;
      string rs, rd;
      rs = p ? "R4 src" : "R3 src";
      rd = u ? "R4 dst" : "R3 dst";
      if (s == 1) begin rs = "R8 src"; rd = "R8 dst"; end
      while (n < total) begin
         check(held ? "R6 valid" : "R7 valid", int'(valid), 1);
         check(held ? "R6 src" : rs, int'(src_idx), expect_off(n, v, s, p));
         check(held ? "R6 dst" : (p != u ? "R5 dst" : rd), int'(dst_idx), expect_off(n, v, s, u));
         step = ((k + stall_seed) % 5) != 3;
         held = !step;
         k++;
         @(negedge clk);
         if (step) n++;
      end
      step = 1'b0;
      check("R7 valid_end", int'(valid), 0);
      check("R7 done_on", int'(done), 1);
      @(negedge clk);
      check("R7 done_off", int'(done), 0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      check("R1 valid", int'(valid), 0);
      check("R1 done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 worked example: VL=2 SUBVL=3 pack -> src 0,3,1,4,2,5
      do_start(2, 3, 1'b1, 1'b0);
      check("R2 src", int'(src_idx), 0);
      check("R2 dst", int'(dst_idx), 0);
      walk(2, 3, 1'b1, 1'b0, 0);

      for (int v = 1; v <= 8; v++)
         for (int s = 1; s <= 4; s++)
            for (int f = 0; f < 4; f++) begin
               do_start(v, s, f[0], f[1]);
               walk(v, s, f[0], f[1], v + s + f);
            end

      // R9 empty starts
      do_start(0, 3, 1'b1, 1'b0);
      check("R9 valid", int'(valid), 0);
      check("R9 done", int'(done), 1);
      @(negedge clk);
      check("R9 done_off", int'(done), 0);
      do_start(5, 0, 1'b0, 1'b1);
      check("R9 valid_sub0", int'(valid), 0);
      check("R9 done_sub0", int'(done), 1);
      @(negedge clk);
      check("R9 done_off_sub0", int'(done), 0);

      // R10 restart mid-walk
      do_start(4, 4, 1'b1, 1'b0);
      step = 1'b1;
      repeat (5) @(negedge clk);
      check("R10 midwalk_valid", int'(valid), 1);
      do_start(3, 2, 1'b0, 1'b1);
      check("R10 src0", int'(src_idx), 0);
      check("R10 dst0", int'(dst_idx), 0);
      walk(3, 2, 1'b0, 1'b1, 1);

      finish_run();
   end
endmodule